// File: doc/BRIEF.md
# Strap-Enabled Watchdog Timer

This block is a watchdog that a board-level strap can turn on at power-on. The strap level is captured while reset is held and cannot change until the next reset. When the strap has armed the watchdog, a prescaler and a tick counter run together and measure a fixed number of clock cycles. If software does not send a kick pulse before that count runs out, the block pulls an open-drain alarm line low. The line stays low until a kick or a reset arrives.

The alarm pin is never driven high. It is either released to high impedance, so that an external pull-up sets its level, or it is driven to 0. The interval is a fixed number of cycles. With the default parameters the count is ten seconds at 24 MHz, and the same count gives five seconds when the input clock is 48 MHz. A kick reloads the full interval and releases the pin on the next clock edge.

Top module: `strap_wdt`

## Requirements
- R1: The level of `strap_en` captured while `rst_n` is low decides whether the watchdog is armed. When it was 0, `pull_low` stays 0 for the whole time between resets.
- R2: A change on `strap_en` after reset is released has no effect on whether the watchdog is armed or on `pull_low`.
- R3: When armed and not kicked, `pull_low` goes to 1 after exactly TIMEOUT = PRE_DIV*TICKS rising clock edges, counting from the first edge at which `rst_n` is high.
- R4: While `pull_low` is 1, `wdt_out` is driven to 0. While `pull_low` is 0, `wdt_out` is high impedance.
- R5: Once `pull_low` is 1, it stays 1 until a kick is sampled or reset is asserted.
- R6: When armed, a kick sampled at clock edge K restarts the interval, so that `pull_low` goes to 1 after edge K+TIMEOUT unless another kick comes first.
- R7: A kick sampled while `pull_low` is 1 clears `pull_low` at that same clock edge.
- R8: A kick while the watchdog is disarmed has no effect: `pull_low` stays 0.
- R9: Asserting `rst_n` low clears `pull_low` at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; the strap is captured while it is low |
| strap_en | input | 1 | Power-on strap that arms the watchdog |
| kick | input | 1 | Software service pulse, one cycle wide, sampled on `clk` |
| pull_low | output | 1 | High while the alarm is active; enables the pad driver |
| wdt_out | output | 1 | Open-drain alarm pin: 0 or high impedance |

## Verification
The bench builds the block with PRE_DIV=4 and TICKS=5, which gives a 20-cycle interval in place of the hundreds of millions of cycles that the defaults produce. With that short interval, the exact expiry edge, a kick on the last edge before expiry, re-expiry after a kick, and long hold periods after expiry all fit in a few hundred cycles. A prescaler of 4 also lets the checks show that the tick phase restarts on a kick instead of carrying over.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic {
        PAD_RELEASED = 1'b0,
        PAD_PULL_LOW = 1'b1
    } pad_state_e;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRE_DIV = 2_400_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);
    localparam int PW = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(PRE_DIV - 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } pre_state_t;

    pre_state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        tick = run && !restart && (s_q.cnt == LAST);
        if (restart) begin
            s_d.cnt = '0;
        end else if (run) begin
            s_d.cnt = tick ? '0 : s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/wdt_tick_counter.sv
module wdt_tick_counter
    import wdt_pkg::*;
#(
    parameter int TICKS = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strap_en,
    input  logic       kick,
    input  logic       tick,
    output logic       armed,
    output logic       run,
    output logic       restart,
    output pad_state_e pad_state
);
    localparam int TW = $clog2(TICKS + 1);
    localparam logic [TW-1:0] FULL = TW'(TICKS);

    typedef struct packed {
        logic          armed;
        logic          expired;
        logic [TW-1:0] left;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    assign armed     = s_q.armed;
    assign pad_state = s_q.expired ? PAD_PULL_LOW : PAD_RELEASED;

    always_comb begin
        s_d     = s_q;
        restart = s_q.armed && kick;
        run     = s_q.armed && !s_q.expired;
        if (restart) begin
            s_d.left    = FULL;
            s_d.expired = 1'b0;
        end else if (tick) begin
            if (s_q.left == TW'(1)) begin
                s_d.expired = 1'b1;
                s_d.left    = FULL;
            end else begin
                s_d.left = s_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.armed   <= strap_en;
            s_q.expired <= 1'b0;
            s_q.left    <= FULL;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/wdt_pad.sv
module wdt_pad
    import wdt_pkg::*;
(
    input  pad_state_e state,
    output wire        pin
);
    assign pin = (state == PAD_PULL_LOW) ? 1'b0 : 1'bz;
endmodule

// File: rtl/strap_wdt.sv
module strap_wdt
    import wdt_pkg::*;
#(
    parameter int PRE_DIV = 2_400_000,
    parameter int TICKS   = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strap_en,
    input  logic kick,
    output logic pull_low,
    output wire  wdt_out
);
    logic       tick;
    logic       armed;
    logic       run;
    logic       restart;
    pad_state_e pad_state;

    wdt_prescaler #(.PRE_DIV(PRE_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (restart),
        .tick    (tick)
    );

    wdt_tick_counter #(.TICKS(TICKS)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_en  (strap_en),
        .kick      (kick),
        .tick      (tick),
        .armed     (armed),
        .run       (run),
        .restart   (restart),
        .pad_state (pad_state)
    );

    wdt_pad u_pad (
        .state (pad_state),
        .pin   (wdt_out)
    );

    assign pull_low = (pad_state == PAD_PULL_LOW);
endmodule

// File: rtl/strap_wdt_chk.sv
module strap_wdt_chk #(
    parameter int PRE_DIV = 2_400_000,
    parameter int TICKS   = 100
) (
    input logic clk,
    input logic rst_n,
    input logic kick,
    input logic armed,
    input logic pull_low,
    input wire  wdt_out
);
    localparam int TIMEOUT = PRE_DIV * TICKS;
    localparam int CW      = $clog2(TIMEOUT + 2);

    logic [CW-1:0] cyc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q <= '0;
        end else if (kick) begin
            cyc_q <= '0;
        end else if (cyc_q <= CW'(TIMEOUT)) begin
            cyc_q <= cyc_q + 1'b1;
        end
    end

    // R1
    a_r1_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !armed |-> !pull_low);
    // R2
    a_r2_strap_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> $stable(armed));
    // R3 / R6
    a_r3_exact_interval: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pull_low) |-> (cyc_q == CW'(TIMEOUT)));
    // R4
    a_r4_pin_low: assert property (@(posedge clk) disable iff (!rst_n)
        pull_low |-> (wdt_out == 1'b0));
    // R5
    a_r5_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (pull_low && !kick) |=> pull_low);
    // R7
    a_r7_kick_release: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !pull_low);
endmodule

bind strap_wdt strap_wdt_chk #(.PRE_DIV(PRE_DIV), .TICKS(TICKS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .kick     (kick),
    .armed    (armed),
    .pull_low (pull_low),
    .wdt_out  (wdt_out)
);

// File: tb/strap_wdt_bench.sv
`timescale 1ns/1ps
module strap_wdt_bench;
    localparam int PRE_DIV = 4;
    localparam int TICKS   = 5;
    localparam int T       = PRE_DIV * TICKS;
    localparam int WIN     = 60;
    localparam int NVEC    = 6;

    // each entry: {strap, kick edge (0 = none), expected expiry edge (0 = none)}
    localparam logic [16:0] VEC [NVEC] = '{
        {1'b1, 8'd0,  8'd20},  // R3
        {1'b1, 8'd5,  8'd26},  // R6
        {1'b1, 8'd19, 8'd40},  // R6 kick on last edge before expiry
        {1'b1, 8'd1,  8'd22},  // R6
        {1'b0, 8'd0,  8'd0},   // R1
        {1'b0, 8'd3,  8'd0}    // R8
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strap_en = 1'b0;
    logic kick = 1'b0;
    logic pull_low;
    wire  wdt_out;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    strap_wdt #(.PRE_DIV(PRE_DIV), .TICKS(TICKS)) u_strap_wdt (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_en (strap_en),
        .kick     (kick),
        .pull_low (pull_low),
        .wdt_out  (wdt_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic strap);
        @(negedge clk);
        rst_n    = 1'b0;
        strap_en = strap;
        kick     = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // advance n edges; return first edge (1-based) where pull_low seen, 0 if none
    task automatic run_edges(input int n, input int kick_at, output int first);
        first = 0;
        for (int e = 1; e <= n; e++) begin
            @(posedge clk);
            @(negedge clk);
            if (pull_low && first == 0) first = e;
            kick = (kick_at != 0 && e == kick_at);
        end
        kick = 1'b0;
    endtask

    task automatic kick_once();
        kick = 1'b1;
        @(posedge clk);
        @(negedge clk);
        kick = 1'b0;
    endtask

    initial begin
        int first;
        for (int i = 0; i < NVEC; i++) begin
            do_reset(VEC[i][16]);
            run_edges(WIN, int'(VEC[i][15:8]), first);
            chk($sformatf("R3/R6/R1/R8 vector %0d expiry edge", i), first, int'(VEC[i][7:0]));
        end

        // reset state
        @(negedge clk); rst_n = 1'b0; strap_en = 1'b1;
        @(negedge clk);
        chk("R9 pull_low in reset", int'(pull_low), 0);

        // R2: strap dropped after release is ignored
        do_reset(1'b1);
        strap_en = 1'b0;
        run_edges(WIN, 0, first);
        chk("R2 strap drop ignored, expiry edge", first, T);

        // R5 / R4: stays low
        run_edges(30, 0, first);
        chk("R5 still low 30 edges later", int'(pull_low), 1);
        chk("R4 pin driven 0 while alarm", int'(wdt_out === 1'b0), 1);

        // R7 then R6 re-expiry
        kick_once();
        chk("R7 kick releases alarm", int'(pull_low), 0);
        run_edges(WIN, 0, first);
        chk("R6 re-expiry edge after kick", first, T);

        // R9: async reset clears alarm
        #1 rst_n = 1'b0;
        #0.5;
        chk("R9 async reset clears", int'(pull_low), 0);

        // R2: strap raised after disarmed release is ignored
        do_reset(1'b0);
        strap_en = 1'b1;
        run_edges(WIN, 0, first);
        chk("R2 strap rise ignored", first, 0);

        // R8: repeated kicks while disarmed
        run_edges(10, 4, first);
        chk("R8 kick while disarmed", int'(pull_low), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule